// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block sits in front of a processor core and turns several interrupt sources into a single hard-interrupt request plus the trap type the core should take. The sources are fifteen external level lines (levels 1 to 15), a software-interrupt register, and a vector-interrupt channel that is raised or lowered by a one-cycle strobe carrying a 5-bit source number.

Level sources are merged into one pending vector. The two timer-match bits of the software-interrupt register do not count at their own positions; either of them forces level 14. The highest pending level above the core's current interrupt level wins, as long as interrupts are globally enabled and no higher external-interrupt trap is already being serviced at a nonzero trap level. The vector channel outranks every level. While it is busy, level arbitration is frozen. It also loads three data words that the core reads when it takes the vector trap.

Arbitration is worked out combinationally every cycle. The request and the trap type are registered, so any change at the inputs shows at the outputs one clock later.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, or whenever reset is asserted, `irq_req`, `trap_type`, `vec_busy` and all three vector data words are zero.
- R2: The pending vector is the OR of `ext_lvl` (bit k is level k+1) and `swi[15:0]`, with `swi[0]` (tick match) and `swi[16]` (system-tick match) ignored at their own positions. Either of those two bits set makes level 14 pending.
- R3: A level request is possible only when some pending level is strictly above `cur_pil`. If none is, an asserted request drops and `trap_type` returns to 0 on the next cycle.
- R4: With `int_en` high and no vector busy, the highest pending level L above `cur_pil` raises `irq_req` with `trap_type` = 0x40 | L on the next cycle.
- R5: No new level request is raised when `trap_lvl` is nonzero and `trap_type_cur` is both above the new trap type and inside the external group (`trap_type_cur[8:4]` = 0x04). A zero trap level or a trap type outside the group does not suppress.
- R6: When `int_en` is low, an asserted level request drops and `trap_type` returns to 0 on the next cycle.
- R7: A raise strobe (`vec_stb`=1, `vec_up`=1) while not busy sets `vec_busy` and `irq_req` and sets `trap_type` to 0x60. It loads data word 0 with 0x7C0 | `vec_src` and data words 1 and 2 with zero. A raise takes priority over any pending level.
- R8: While `vec_busy` is set, level inputs do not change `irq_req` or `trap_type`, and a further raise strobe changes nothing. Level arbitration resumes on the cycle after the busy flag clears.
- R9: A lower strobe (`vec_stb`=1, `vec_up`=0) while busy clears `vec_busy` and `irq_req`. A lower strobe while idle has no effect.
- R10: While a level request is asserted, a newly pending higher level replaces `trap_type` on the next cycle. A newly pending lower level leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lvl | input | 15 | External level lines, bit k is level k+1 |
| swi | input | 17 | Software-interrupt register; bit 0 tick match, bit 16 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| trap_type_cur | input | 9 | Trap type held at the current trap level |
| vec_stb | input | 1 | Vector strobe, one cycle |
| vec_up | input | 1 | With strobe: 1 raise, 0 lower |
| vec_src | input | 5 | Vector source number |
| irq_req | output | 1 | Hard-interrupt request |
| trap_type | output | 9 | Selected trap type |
| vec_busy | output | 1 | Vector interrupt pending |
| vec_data0 | output | 64 | Vector data word 0 |
| vec_data1 | output | 64 | Vector data word 1 |
| vec_data2 | output | 64 | Vector data word 2 |

## Verification
A sequence of level patterns is run through the arbiter. It covers single and multiple external levels, software levels, each timer-match bit alone and together with level 15, and all levels pending with the current level at 14 and at 15. Together these separate a wrong merge, a wrong priority order and an off-by-one threshold. Nested-trap patterns set the held trap type inside and outside the external group and at trap level zero and nonzero, which separates each term of the suppression rule. Directed vector sequences cover a raise that coincides with a pending level, a raise and pending levels while busy, a lower in the busy state and in the idle state, and reset taken while a request is up.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int TT_W      = 9;
   localparam int GRP_LSB   = 4;
   localparam logic [TT_W-1:0] EXT_BASE = 9'h040;
   localparam logic [TT_W-1:0] GRP_MASK = 9'h1F0;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SET   = 2'd1,
      ACT_CLEAR = 2'd2
   } arb_act_e;
endpackage

// File: rtl/pend_merge.sv
module pend_merge #(
   parameter int LVLS     = 16,
   parameter int SWI_W    = 17,
   parameter int TM_BIT   = 0,
   parameter int SM_BIT   = 16,
   parameter int FOLD_LVL = 14
) (
   input  logic [LVLS-1:1]  ext_lvl,
   input  logic [SWI_W-1:0] swi,
   output logic [LVLS-1:0]  pend
);
   localparam int LOW_W = (SWI_W < LVLS) ? SWI_W : LVLS;

   logic [SWI_W-1:0] swi_clean;
   logic [LVLS-1:0]  swi_lvls;
   logic             tmr_hit;

   if (FOLD_LVL >= LVLS) begin : g_bad_fold
      $error("pend_merge: FOLD_LVL outside level range");
   end
   if (TM_BIT >= SWI_W || SM_BIT >= SWI_W) begin : g_bad_tmr
      $error("pend_merge: timer bit outside register");
   end

   always_comb begin
      swi_clean         = swi;
      swi_clean[TM_BIT] = 1'b0;
      swi_clean[SM_BIT] = 1'b0;
      tmr_hit           = swi[TM_BIT] | swi[SM_BIT];
      swi_lvls          = '0;
      swi_lvls[LOW_W-1:0] = swi_clean[LOW_W-1:0];
   end

   for (genvar i = 0; i < LVLS; i++) begin : g_lvl
      logic ext_bit;
      if (i == 0) begin : g_zero
         assign ext_bit = 1'b0;
      end else begin : g_ext
         assign ext_bit = ext_lvl[i];
      end
      if (i == FOLD_LVL) begin : g_fold
         assign pend[i] = ext_bit | swi_lvls[i] | tmr_hit;
      end else begin : g_plain
         assign pend[i] = ext_bit | swi_lvls[i];
      end
   end
endmodule

// File: rtl/lvl_pick.sv
module lvl_pick #(
   parameter int LVLS  = 16,
   parameter int PIL_W = 4
) (
   input  logic [LVLS-1:0]  pend,
   input  logic [PIL_W-1:0] cur_pil,
   output logic             any_above,
   output logic [PIL_W-1:0] win_lvl,
   output logic [LVLS-1:0]  win_oh
);
   logic [LVLS-1:0] above;
   logic [LVLS-1:0] cand;

   if (LVLS > (1 << PIL_W)) begin : g_bad_w
      $error("lvl_pick: PIL_W too narrow for LVLS");
   end

   for (genvar i = 0; i < LVLS; i++) begin : g_above
      assign above[i] = (PIL_W'(i) > cur_pil);
   end

   assign cand      = pend & above;
   assign any_above = |cand;

   always_comb begin
      win_lvl = '0;
      win_oh  = '0;
      for (int i = 0; i < LVLS; i++) begin
         if (cand[i]) begin
            win_lvl = PIL_W'(i);
            win_oh  = '0;
            win_oh[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vec_slot.sv
module vec_slot #(
   parameter int SRC_W     = 5,
   parameter int DATA_W    = 64,
   parameter int TAG_SHIFT = 6,
   parameter int TAG_W     = 5,
   parameter int NWORDS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_stb,
   input  logic              vec_up,
   input  logic [SRC_W-1:0]  vec_src,
   output logic              take,
   output logic              drop,
   output logic              busy,
   output logic [DATA_W-1:0] words [NWORDS]
);
   localparam logic [DATA_W-1:0] TAG_VAL = DATA_W'({TAG_W{1'b1}}) << TAG_SHIFT;

   if (SRC_W > TAG_SHIFT || TAG_SHIFT + TAG_W > DATA_W) begin : g_bad_fmt
      $error("vec_slot: data word format does not fit");
   end

   logic busy_q;

   assign take = vec_stb &  vec_up & ~busy_q;
   assign drop = vec_stb & ~vec_up &  busy_q;
   assign busy = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (take)   busy_q <= 1'b1;
      else if (drop)   busy_q <= 1'b0;
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [DATA_W-1:0] load_val;
      if (w == 0) begin : g_tagged
         assign load_val = TAG_VAL | DATA_W'(vec_src);
      end else begin : g_blank
         assign load_val = '0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)    words[w] <= '0;
         else if (take) words[w] <= load_val;
      end
   end

   p_busy_raise_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !drop |=> busy_q && $stable(words[0]));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int LVLS   = 16,
   parameter int PIL_W  = 4,
   parameter int SWI_W  = 17,
   parameter int TL_W   = 3,
   parameter int SRC_W  = 5,
   parameter int DATA_W = 64,
   parameter logic [TT_W-1:0] VEC_TT = 9'h060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVLS-2:0]   ext_lvl,
   input  logic [SWI_W-1:0]  swi,
   input  logic [PIL_W-1:0]  cur_pil,
   input  logic              int_en,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [TT_W-1:0]   trap_type_cur,
   input  logic              vec_stb,
   input  logic              vec_up,
   input  logic [SRC_W-1:0]  vec_src,
   output logic              irq_req,
   output logic [TT_W-1:0]   trap_type,
   output logic              vec_busy,
   output logic [DATA_W-1:0] vec_data0,
   output logic [DATA_W-1:0] vec_data1,
   output logic [DATA_W-1:0] vec_data2
);
   localparam int NWORDS = 3;

   if (PIL_W > GRP_LSB) begin : g_bad_pil
      $error("irq_level_arbiter: level field overlaps group field");
   end

   logic [LVLS-1:0]   pend;
   logic              any_above;
   logic [PIL_W-1:0]  win_lvl;
   logic [LVLS-1:0]   win_oh;
   logic              take, drop, busy;
   logic [DATA_W-1:0] words [NWORDS];
   logic [TT_W-1:0]   new_tt;
   logic              nest_block;
   arb_act_e          act;
   logic              req_q;
   logic [TT_W-1:0]   tt_q;

   pend_merge #(.LVLS(LVLS), .SWI_W(SWI_W)) u_merge (
      .ext_lvl (ext_lvl),
      .swi     (swi),
      .pend    (pend)
   );

   lvl_pick #(.LVLS(LVLS), .PIL_W(PIL_W)) u_pick (
      .pend      (pend),
      .cur_pil   (cur_pil),
      .any_above (any_above),
      .win_lvl   (win_lvl),
      .win_oh    (win_oh)
   );

   vec_slot #(.SRC_W(SRC_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .vec_stb (vec_stb),
      .vec_up  (vec_up),
      .vec_src (vec_src),
      .take    (take),
      .drop    (drop),
      .busy    (busy),
      .words   (words)
   );

   assign new_tt     = EXT_BASE | TT_W'(win_lvl);
   assign nest_block = (trap_lvl != '0) && (trap_type_cur > new_tt) &&
                       ((trap_type_cur & GRP_MASK) == EXT_BASE);

   always_comb begin
      act = ACT_HOLD;
      if (!any_above || !int_en) begin
         if (req_q) act = ACT_CLEAR;
      end else if (!nest_block && tt_q != new_tt) begin
         act = ACT_SET;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         tt_q  <= '0;
      end else if (take) begin
         req_q <= 1'b1;
         tt_q  <= VEC_TT;
      end else if (drop) begin
         req_q <= 1'b0;
      end else if (!busy) begin
         case (act)
            ACT_SET: begin
               req_q <= 1'b1;
               tt_q  <= new_tt;
            end
            ACT_CLEAR: begin
               req_q <= 1'b0;
               tt_q  <= '0;
            end
            default: ;
         endcase
      end
   end

   assign irq_req   = req_q;
   assign trap_type = tt_q;
   assign vec_busy  = busy;
   assign vec_data0 = words[0];
   assign vec_data1 = words[1];
   assign vec_data2 = words[2];

   p_level_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !vec_busy |-> (trap_type & GRP_MASK) == EXT_BASE);
   p_winner_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_oh) && (any_above == (win_oh != '0)));
   p_below_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_above && !vec_busy && !vec_stb |=> !irq_req);
   p_disabled_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en && !vec_busy && !vec_stb |=> !irq_req);
   p_vec_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && vec_up && !vec_busy |=> vec_busy && irq_req && trap_type == VEC_TT);
   p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy && !vec_stb |=> vec_busy && $stable(trap_type) && $stable(irq_req));
   p_vec_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && !vec_up && vec_busy |=> !vec_busy && !irq_req);
endmodule

// File: tb/sim_irq_level_arbiter.sv
`timescale 1ns/1ps
module sim_irq_level_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] ext_lvl = '0;
   logic [16:0] swi = '0;
   logic [3:0]  cur_pil = '0;
   logic        int_en = 1'b1;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  trap_type_cur = '0;
   logic        vec_stb = 1'b0;
   logic        vec_up = 1'b0;
   logic [4:0]  vec_src = '0;
   logic        irq_req;
   logic [8:0]  trap_type;
   logic        vec_busy;
   logic [63:0] vec_data0, vec_data1, vec_data2;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_level_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .swi(swi), .cur_pil(cur_pil),
      .int_en(int_en), .trap_lvl(trap_lvl), .trap_type_cur(trap_type_cur),
      .vec_stb(vec_stb), .vec_up(vec_up), .vec_src(vec_src),
      .irq_req(irq_req), .trap_type(trap_type), .vec_busy(vec_busy),
      .vec_data0(vec_data0), .vec_data1(vec_data1), .vec_data2(vec_data2)
   );

   // row: {req_no[4], ext16[16] (bit0 unused), swi[17], pil[4], ien, tl[3], ttc[9], ereq, ett[9]}
   localparam int NROWS = 22;
   localparam logic [63:0] ROWS [NROWS] = '{
      {4'd4,  16'h0020, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h045},
      {4'd10, 16'h0220, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h049}, // R10 higher replaces
      {4'd10, 16'h0208, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h049}, // R10 lower keeps
      {4'd3,  16'h0208, 17'h00000, 4'd9,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3 equal level
      {4'd3,  16'h0208, 17'h00000, 4'd8,  1'b1, 3'd0, 9'h000, 1'b1, 9'h049}, // R3 one above
      {4'd6,  16'h0208, 17'h00000, 4'd8,  1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R6
      {4'd2,  16'h0000, 17'h00001, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04E}, // R2 tick match
      {4'd2,  16'h0000, 17'h10000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04E}, // R2 sys tick
      {4'd2,  16'h0000, 17'h18000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h04F}, // R2
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3 none
      {4'd2,  16'h0000, 17'h00080, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 9'h047}, // R2 sw level
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000},
      {4'd5,  16'h0010, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h04A, 1'b0, 9'h000}, // R5 suppressed
      {4'd5,  16'h0010, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h043, 1'b1, 9'h044}, // R5 lower held
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h043, 1'b0, 9'h000},
      {4'd5,  16'h0010, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h04A, 1'b1, 9'h044}, // R5 tl zero
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000},
      {4'd5,  16'h0010, 17'h00000, 4'd0,  1'b1, 3'd2, 9'h08A, 1'b1, 9'h044}, // R5 other group
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000},
      {4'd3,  16'hFFFE, 17'h00000, 4'd15, 1'b1, 3'd0, 9'h000, 1'b0, 9'h000}, // R3 top level
      {4'd4,  16'hFFFE, 17'h00000, 4'd14, 1'b1, 3'd0, 9'h000, 1'b1, 9'h04F}, // R4 all pending
      {4'd3,  16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 9'h000}
   };

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset req", {63'd0, irq_req}, 64'd0);
      chk("R1 reset type", {55'd0, trap_type}, 64'd0);
      chk("R1 reset busy", {63'd0, vec_busy}, 64'd0);
      chk("R1 reset data0", vec_data0, 64'd0);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NROWS; i++) begin
         logic [63:0] r;
         r = ROWS[i];
         ext_lvl       = r[59:45];
         swi           = r[43:27];
         cur_pil       = r[26:23];
         int_en        = r[22];
         trap_lvl      = r[21:19];
         trap_type_cur = r[18:10];
         step();
         tests++;
         if (irq_req !== r[9] || trap_type !== r[8:0]) begin
            fails++;
            $display("FAIL R%0d row %0d: got req=%0b type=%0h expected req=%0b type=%0h",
                     r[63:60], i, irq_req, trap_type, r[9], r[8:0]);
         end
      end

      // R7: raise together with a pending level
      ext_lvl = 15'h0004; cur_pil = '0; int_en = 1'b1; trap_lvl = '0; trap_type_cur = '0; swi = '0;
      vec_stb = 1'b1; vec_up = 1'b1; vec_src = 5'd5;
      step();
      vec_stb = 1'b0;
      chk("R7 type", {55'd0, trap_type}, 64'h060);
      chk("R7 req", {63'd0, irq_req}, 64'd1);
      chk("R7 busy", {63'd0, vec_busy}, 64'd1);
      chk("R7 data0", vec_data0, 64'h7C5);
      chk("R7 data1", vec_data1, 64'd0);
      chk("R7 data2", vec_data2, 64'd0);
      // R8: pending levels do nothing while busy
      step();
      chk("R8 frozen type", {55'd0, trap_type}, 64'h060);
      chk("R8 frozen req", {63'd0, irq_req}, 64'd1);
      vec_stb = 1'b1; vec_up = 1'b1; vec_src = 5'd9;
      step();
      vec_stb = 1'b0;
      chk("R8 second raise data0", vec_data0, 64'h7C5);
      chk("R8 second raise type", {55'd0, trap_type}, 64'h060);
      // R9: lower while busy
      vec_stb = 1'b1; vec_up = 1'b0;
      step();
      vec_stb = 1'b0;
      chk("R9 lower busy", {63'd0, vec_busy}, 64'd0);
      chk("R9 lower req", {63'd0, irq_req}, 64'd0);
      // R8: arbitration resumes
      step();
      chk("R8 resume type", {55'd0, trap_type}, 64'h043);
      chk("R8 resume req", {63'd0, irq_req}, 64'd1);
      // R9: lower while idle ignored
      vec_stb = 1'b1; vec_up = 1'b0;
      step();
      vec_stb = 1'b0;
      chk("R9 idle lower req", {63'd0, irq_req}, 64'd1);
      chk("R9 idle lower type", {55'd0, trap_type}, 64'h043);
      chk("R9 idle lower busy", {63'd0, vec_busy}, 64'd0);
      // R1: reset mid-run after another vector
      vec_stb = 1'b1; vec_up = 1'b1; vec_src = 5'd31;
      step();
      vec_stb = 1'b0;
      chk("R7 data0 max src", vec_data0, 64'h7DF);
      rst_n = 1'b0;
      step();
      chk("R1 mid reset req", {63'd0, irq_req}, 64'd0);
      chk("R1 mid reset type", {55'd0, trap_type}, 64'd0);
      chk("R1 mid reset busy", {63'd0, vec_busy}, 64'd0);
      chk("R1 mid reset data0", vec_data0, 64'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule